// File: doc/BRIEF.md
# Smart Card Protocol Timeout Timer

This block holds three independent down-counting channels that time protocol intervals on a smart card (ISO 7816 style) interface, such as character waits and the answer-to-reset (ATR) window. Software gives each channel a 4-bit mode code, a count value and enable set/clear strobes. The interface logic around the block supplies single-cycle event strobes: start bit seen on receive, start bit seen on transmit, card reset released, and ATR received. A shared `tick_i` strobe marks one elementary time unit. A channel decrements only on cycles where `tick_i` is high.

Each channel runs a small state machine with three states. In `ST_IDLE` the channel is disabled. In `ST_ARMED` it is enabled and waits for its start event. In `ST_RUN` it is counting. The transitions are:

- IDLE→RUN on enable in a mode that starts at once.
- IDLE→ARMED on enable in any other mode.
- ARMED→RUN on the mode's start event.
- RUN→IDLE on expiry in a one-shot mode, on ATR cancel, or on software clear.
- ARMED→IDLE on software clear.
- RUN→RUN on a periodic reload.

An expiry sets a sticky per-channel flag, which software clears by writing 1. Channel 0 has a 24-bit count; channels 1 and 2 have 8-bit counts.

Top module: `sc_tout_timer`

## Requirements
- R1: After reset, every enable, active and flag output is 0.
- R2: Mode 0000 enters RUN on the enable strobe. After count+1 ticks it sets the channel flag and returns to IDLE, so the enable clears.
- R3: Mode 0001 enters ARMED on enable, with enable 1 and active 0, and ignores ticks while armed. A receive or a transmit start strobe moves it to RUN. The expiry rule is as in R2.
- R4: Mode 0010 is like R3, but only a receive start strobe starts it. A transmit start strobe leaves it armed.
- R5: Mode 0011 on channel 0 arms on enable and starts on the card-reset-released strobe. Other strobes do not start it. After count+1 ticks with no ATR, it sets flag 0 and clears the enable.
- R6: In mode 0011, an ATR strobe while running returns channel 0 to IDLE with no flag set.
- R7: Mode 0100 sets the flag every count+1 ticks, reloads, and stays enabled and active until software clears the enable.
- R8: In mode 0100, a count rewritten while running is used at the next reload. The interval in progress is not changed.
- R9: Flags are sticky until a flag-clear strobe. A clear strobe in the same cycle as an expiry leaves the flag set.
- R10: A mode code outside 0000–0100, or 0011 on channel 1 or 2, never reaches RUN. The channel stays armed until cleared.
- R11: The enable-clear strobe returns a channel to IDLE from any state without setting its flag.
- R12: Channel 0 counts the full 24-bit range, so a count above 255 gives count+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One elementary time unit strobe |
| rx_start_i | input | 1 | Start bit seen on receive |
| tx_start_i | input | 1 | Start bit seen on transmit |
| rst_rel_i | input | 1 | Card reset released strobe |
| atr_rcvd_i | input | 1 | ATR received strobe |
| mode_i | input | 12 | Mode codes, channel n at bits [4n+3:4n] |
| cnt0_i | input | CNT0_W | Count value, channel 0 |
| cnt1_i | input | CNTN_W | Count value, channel 1 |
| cnt2_i | input | CNTN_W | Count value, channel 2 |
| en_set_i | input | 3 | Enable set strobes, bit n per channel |
| en_clr_i | input | 3 | Enable clear strobes |
| flag_clr_i | input | 3 | Write-1 flag clear strobes |
| en_o | output | 3 | Channel enabled (ARMED or RUN) |
| active_o | output | 3 | Channel counting (RUN) |
| flag_o | output | 3 | Sticky expiry flags |

## Verification
The bench checks the exact expiry cycle: a channel must still be active after count ticks and must stop on the next tick. A design that expired at count ticks, or at count+2, fails this check.

It also drives start strobes that are wrong for the mode. A transmit start in mode 0010, a receive start in mode 0011, and card reset release on a channel without ATR support must all leave the channel armed. A design that decoded the start condition too loosely would start counting.

For the watchdog mode, an ATR mid-count must cancel without a flag. For the periodic mode, the count is rewritten between reloads, and a clear strobe is placed in the same cycle as an expiry. These catch a design that raised the flag on cancel, loaded the new count at once, or let the clear win.

// File: rtl/sc_tout_pkg.sv
package sc_tout_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ch_state_e;

    localparam logic [MODE_W-1:0] MD_ONESHOT  = 4'b0000;
    localparam logic [MODE_W-1:0] MD_ANYSTART = 4'b0001;
    localparam logic [MODE_W-1:0] MD_RXSTART  = 4'b0010;
    localparam logic [MODE_W-1:0] MD_ATRWD    = 4'b0011;
    localparam logic [MODE_W-1:0] MD_PERIODIC = 4'b0100;
endpackage

// File: rtl/sc_tout_chan.sv
module sc_tout_chan
    import sc_tout_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter bit HAS_ATR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_start_i,
    input  logic              tx_start_i,
    input  logic              rst_rel_i,
    input  logic              atr_rcvd_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              flag_clr_i,
    output logic              en_o,
    output logic              active_o,
    output logic              flag_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    logic imm_start, evt_start, at_zero, atr_cancel, expire, load;

    // Start condition decode for each mode
    always_comb begin
        imm_start = (mode_i == MD_ONESHOT) || (mode_i == MD_PERIODIC);
        evt_start = ((mode_i == MD_ANYSTART) && (rx_start_i || tx_start_i)) ||
                    ((mode_i == MD_RXSTART) && rx_start_i) ||
                    (HAS_ATR && (mode_i == MD_ATRWD) && rst_rel_i);
        at_zero    = (cnt_q == '0);
        atr_cancel = HAS_ATR && (state_q == ST_RUN) && (mode_i == MD_ATRWD) && atr_rcvd_i;
        expire     = (state_q == ST_RUN) && tick_i && at_zero && !atr_cancel && !en_clr_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_set_i && !en_clr_i)
                    state_d = imm_start ? ST_RUN : ST_ARMED;
            end
            ST_ARMED: begin
                if (en_clr_i)       state_d = ST_IDLE;
                else if (evt_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (en_clr_i || atr_cancel)                  state_d = ST_IDLE;
                else if (expire && (mode_i != MD_PERIODIC))  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign load = (state_q != ST_RUN) && (state_d == ST_RUN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Down counter with reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cnt_i;
        end else if ((state_q == ST_RUN) && tick_i) begin
            if (at_zero) cnt_q <= cnt_i;
            else         cnt_q <= cnt_q - ONE;
        end
    end

    // Sticky flag: expiry wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (expire)     flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Outputs
    always_comb begin
        en_o     = 1'b0;
        active_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin en_o = 1'b0; active_o = 1'b0; end
            ST_ARMED: begin en_o = 1'b1; active_o = 1'b0; end
            ST_RUN:   begin en_o = 1'b1; active_o = 1'b1; end
            default:  begin en_o = 1'b0; active_o = 1'b0; end
        endcase
        flag_o = flag_q;
    end
endmodule

// File: rtl/sc_tout_timer.sv
module sc_tout_timer
    import sc_tout_pkg::*;
#(
    parameter int CNT0_W = 24,
    parameter int CNTN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                rx_start_i,
    input  logic                tx_start_i,
    input  logic                rst_rel_i,
    input  logic                atr_rcvd_i,
    input  logic [3*MODE_W-1:0] mode_i,
    input  logic [CNT0_W-1:0]   cnt0_i,
    input  logic [CNTN_W-1:0]   cnt1_i,
    input  logic [CNTN_W-1:0]   cnt2_i,
    input  logic [2:0]          en_set_i,
    input  logic [2:0]          en_clr_i,
    input  logic [2:0]          flag_clr_i,
    output logic [2:0]          en_o,
    output logic [2:0]          active_o,
    output logic [2:0]          flag_o
);
    localparam int NCH = 3;

    logic [CNTN_W-1:0] small_cnt [1:NCH-1];
    assign small_cnt[1] = cnt1_i;
    assign small_cnt[2] = cnt2_i;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_wide
            sc_tout_chan #(.CNT_W(CNT0_W), .HAS_ATR(1'b1)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_i     (tick_i),
                .rx_start_i (rx_start_i),
                .tx_start_i (tx_start_i),
                .rst_rel_i  (rst_rel_i),
                .atr_rcvd_i (atr_rcvd_i),
                .mode_i     (mode_i[g*MODE_W +: MODE_W]),
                .cnt_i      (cnt0_i),
                .en_set_i   (en_set_i[g]),
                .en_clr_i   (en_clr_i[g]),
                .flag_clr_i (flag_clr_i[g]),
                .en_o       (en_o[g]),
                .active_o   (active_o[g]),
                .flag_o     (flag_o[g])
            );
        end else begin : g_narrow
            sc_tout_chan #(.CNT_W(CNTN_W), .HAS_ATR(1'b0)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_i     (tick_i),
                .rx_start_i (rx_start_i),
                .tx_start_i (tx_start_i),
                .rst_rel_i  (rst_rel_i),
                .atr_rcvd_i (atr_rcvd_i),
                .mode_i     (mode_i[g*MODE_W +: MODE_W]),
                .cnt_i      (small_cnt[g]),
                .en_set_i   (en_set_i[g]),
                .en_clr_i   (en_clr_i[g]),
                .flag_clr_i (flag_clr_i[g]),
                .en_o       (en_o[g]),
                .active_o   (active_o[g]),
                .flag_o     (flag_o[g])
            );
        end
    end
endmodule

// File: rtl/sc_tout_chk.sv
module sc_tout_chk
    import sc_tout_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic                atr_rcvd_i,
    input logic                rst_rel_i,
    input logic [3*MODE_W-1:0] mode_i,
    input logic [2:0]          en_clr_i,
    input logic [2:0]          flag_clr_i,
    input logic [2:0]          en_o,
    input logic [2:0]          active_o,
    input logic [2:0]          flag_o
);
    for (genvar g = 0; g < 3; g++) begin : g_chk
        // R9: a set flag holds until a clear strobe
        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            flag_o[g] && !flag_clr_i[g] |=> flag_o[g]);

        // R2: a flag rises only out of a running channel on a tick
        p_flag_from_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_o[g] && !(active_o[g] && tick_i) |=> !flag_o[g]);

        // R11: software clear always lands in IDLE
        p_clr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
            en_clr_i[g] |=> !en_o[g] && !active_o[g]);
    end

    // R6: ATR while the watchdog runs cancels without flag
    p_atr_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o[0] && mode_i[3:0] == MD_ATRWD && atr_rcvd_i && !flag_o[0]
        |=> !en_o[0] && !flag_o[0]);

    // R7: periodic mode stays enabled until cleared
    p_periodic_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active_o[0] && mode_i[3:0] == MD_PERIODIC && !en_clr_i[0] |=> active_o[0]);

    // R10: watchdog code on channel 1 never starts
    p_no_wd_ch1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o[1] && mode_i[7:4] == MD_ATRWD |=> !active_o[1]);
endmodule

bind sc_tout_timer sc_tout_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .atr_rcvd_i (atr_rcvd_i),
    .rst_rel_i  (rst_rel_i),
    .mode_i     (mode_i),
    .en_clr_i   (en_clr_i),
    .flag_clr_i (flag_clr_i),
    .en_o       (en_o),
    .active_o   (active_o),
    .flag_o     (flag_o)
);

// File: tb/sc_tout_timer_tb_top.sv
module sc_tout_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, rx_start_i = 1'b0, tx_start_i = 1'b0;
    logic        rst_rel_i = 1'b0, atr_rcvd_i = 1'b0;
    logic [11:0] mode_i = '0;
    logic [23:0] cnt0_i = '0;
    logic [7:0]  cnt1_i = '0, cnt2_i = '0;
    logic [2:0]  en_set_i = '0, en_clr_i = '0, flag_clr_i = '0;
    logic [2:0]  en_o, active_o, flag_o;

    always #2 clk = ~clk;

    sc_tout_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_start_i(rx_start_i),
        .tx_start_i(tx_start_i), .rst_rel_i(rst_rel_i), .atr_rcvd_i(atr_rcvd_i),
        .mode_i(mode_i), .cnt0_i(cnt0_i), .cnt1_i(cnt1_i), .cnt2_i(cnt2_i),
        .en_set_i(en_set_i), .en_clr_i(en_clr_i), .flag_clr_i(flag_clr_i),
        .en_o(en_o), .active_o(active_o), .flag_o(flag_o)
    );

    // Scoreboard: expected {en, active, flag} snapshots with requirement tags
    logic [8:0] exp_q [$];
    string      tag_q [$];
    int         n_chk = 0, n_fail = 0;
    logic [2:0] e_en = '0, e_act = '0, e_flg = '0;
    bit         done = 1'b0;

    task automatic expect_now(input string tag);
        exp_q.push_back({e_en, e_act, e_flg});
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            wait (exp_q.size() > 0);
            begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if ({en_o, active_o, flag_o} !== e) begin
                    n_fail++;
                    $display("FAIL %s: en/act/flag actual %b/%b/%b expected %b/%b/%b",
                             t, en_o, active_o, flag_o, e[8:6], e[5:3], e[2:0]);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; cyc(); tick_i = 1'b0;
        end
    endtask

    task automatic set_en(input int ch);
        en_set_i[ch] = 1'b1; cyc(); en_set_i = '0;
    endtask

    task automatic clr_en(input int ch);
        en_clr_i[ch] = 1'b1; cyc(); en_clr_i = '0;
    endtask

    task automatic clr_flag(input int ch);
        flag_clr_i[ch] = 1'b1; cyc(); flag_clr_i = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) cyc();
        expect_now("R1 reset"); cyc();
        rst_n = 1'b1; cyc();

        // R2: one-shot, channel 1, count 3
        mode_i[7:4] = 4'b0000; cnt1_i = 8'd3;
        set_en(1); e_en[1] = 1; e_act[1] = 1; expect_now("R2 start on enable");
        ticks(3); expect_now("R2 active after count ticks");
        ticks(1); e_en[1] = 0; e_act[1] = 0; e_flg[1] = 1; expect_now("R2 expiry");
        clr_flag(1); e_flg[1] = 0; expect_now("R9 write-1 clear");

        // R12: channel 0 wide count 300
        mode_i[3:0] = 4'b0000; cnt0_i = 24'd300;
        set_en(0); e_en[0] = 1; e_act[0] = 1;
        ticks(300); expect_now("R12 active after 300 ticks");
        ticks(1); e_en[0] = 0; e_act[0] = 0; e_flg[0] = 1; expect_now("R12 expiry at 301");
        clr_flag(0); e_flg[0] = 0;

        // R3: any-start, channel 2, count 2
        mode_i[11:8] = 4'b0001; cnt2_i = 8'd2;
        set_en(2); e_en[2] = 1; expect_now("R3 armed");
        ticks(3); expect_now("R3 no count while armed");
        tx_start_i = 1; cyc(); tx_start_i = 0; e_act[2] = 1; expect_now("R3 tx start");
        ticks(2); expect_now("R3 still running");
        ticks(1); e_en[2] = 0; e_act[2] = 0; e_flg[2] = 1; expect_now("R3 expiry");
        clr_flag(2); e_flg[2] = 0;
        set_en(2); e_en[2] = 1;
        rx_start_i = 1; cyc(); rx_start_i = 0; e_act[2] = 1; expect_now("R3 rx start");
        clr_en(2); e_en[2] = 0; e_act[2] = 0; expect_now("R11 clear while running");

        // R4: rx-only start, channel 1, count 1
        mode_i[7:4] = 4'b0010; cnt1_i = 8'd1;
        set_en(1); e_en[1] = 1;
        tx_start_i = 1; cyc(); tx_start_i = 0; expect_now("R4 tx ignored");
        rx_start_i = 1; cyc(); rx_start_i = 0; e_act[1] = 1; expect_now("R4 rx start");
        ticks(2); e_en[1] = 0; e_act[1] = 0; e_flg[1] = 1; expect_now("R4 expiry");
        clr_flag(1); e_flg[1] = 0;

        // R5: ATR watchdog expiry, channel 0, count 5
        mode_i[3:0] = 4'b0011; cnt0_i = 24'd5;
        set_en(0); e_en[0] = 1;
        rx_start_i = 1; cyc(); rx_start_i = 0; expect_now("R5 rx does not start");
        rst_rel_i = 1; cyc(); rst_rel_i = 0; e_act[0] = 1; expect_now("R5 start on reset release");
        ticks(5); expect_now("R5 running");
        ticks(1); e_en[0] = 0; e_act[0] = 0; e_flg[0] = 1; expect_now("R5 expiry sets flag");
        clr_flag(0); e_flg[0] = 0;

        // R6: ATR cancels
        set_en(0); e_en[0] = 1;
        rst_rel_i = 1; cyc(); rst_rel_i = 0; e_act[0] = 1;
        ticks(2);
        atr_rcvd_i = 1; cyc(); atr_rcvd_i = 0; e_en[0] = 0; e_act[0] = 0;
        expect_now("R6 ATR cancel no flag");
        ticks(8); expect_now("R6 stays idle");

        // R10: unsupported codes
        mode_i[7:4] = 4'b0011; cnt1_i = 8'd1;
        set_en(1); e_en[1] = 1; expect_now("R10 ch1 watchdog code armed");
        rst_rel_i = 1; cyc(); rst_rel_i = 0; ticks(3);
        expect_now("R10 ch1 never starts");
        clr_en(1); e_en[1] = 0; expect_now("R11 clear from armed");
        mode_i[11:8] = 4'b1111;
        set_en(2); e_en[2] = 1;
        rx_start_i = 1; tx_start_i = 1; cyc(); rx_start_i = 0; tx_start_i = 0;
        ticks(2); expect_now("R10 code 1111 never starts");
        clr_en(2); e_en[2] = 0;

        // R7/R8/R9: periodic on channel 2, count 2
        mode_i[11:8] = 4'b0100; cnt2_i = 8'd2;
        set_en(2); e_en[2] = 1; e_act[2] = 1;
        ticks(3); e_flg[2] = 1; expect_now("R7 first period flag, still active");
        cnt2_i = 8'd0;
        clr_flag(2); e_flg[2] = 0;
        ticks(2); expect_now("R8 old count still in effect");
        ticks(1); e_flg[2] = 1; expect_now("R8 second period uses reloaded old count");
        clr_flag(2); e_flg[2] = 0;
        tick_i = 1; flag_clr_i[2] = 1; cyc(); tick_i = 0; flag_clr_i = '0;
        e_flg[2] = 1; expect_now("R8 new count, R9 set wins over clear");
        clr_en(2); e_en[2] = 0; e_act[2] = 0;
        ticks(3); expect_now("R7 stopped only by software clear");
        clr_flag(2); e_flg[2] = 0;

        // R11: clear mid-count, no flag
        mode_i[3:0] = 4'b0000; cnt0_i = 24'd10;
        set_en(0); e_en[0] = 1; e_act[0] = 1;
        ticks(3);
        clr_en(0); e_en[0] = 0; e_act[0] = 0;
        ticks(12); expect_now("R11 no flag after clear");

        cyc();
        wait (exp_q.size() == 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule